// File: doc/BRIEF.md
# Transmit Completion Queue Controller

This block sits between a host register port and a transmit engine. It tracks the packet numbers handed over for transmission. The host submits packet numbers into a transmit queue. The engine takes them from the head of that queue and later reports a result for each one, either success or fatal error, along with a 16-bit status word.

Results go into a completion queue. The host reads that queue through a port register, so the driver never has to keep its own list of packets in flight. Completions can pile up while earlier ones are still unread, because the engine keeps running while the host services the queue.

An auto-release mode handles successful packets differently. They skip the completion queue, and their memory is freed at once through a release strobe that carries the packet number. In that mode the completion queue holds only failures. An empty-queue interrupt then marks the end of a whole batch, while the transmit interrupt reports a fatal error that halts the engine.

Top module: `txcq_ctrl`

Register map (3-bit address): 0 control (write: bit0 auto-release, bit1 transmit-interrupt enable, bit2 empty-interrupt enable, bit3 resume pulse; read: bits 2:0 as written, bit4 halted). 1 status (read: bit0 transmit flag, bit1 empty flag, bit5 overflow; writing 1 to a bit clears it). 2 submit (write bits 5:0 push a packet number). 3 completion head (read). 4 completion status word (read; any write pops the head). Read data appears on `reg_rdata` one cycle after `reg_rd`.

## Requirements
- R1: After reset both queues are empty, every flag is clear, `irq` is low and `tx_head_valid` is low.
- R2: A write to address 2 appends bits 5:0 to the transmit queue. The engine sees the packet numbers on `tx_head_pnum` in submission order, and each accepted `tx_pop` advances the queue by one.
- R3: With auto-release clear, every completion, whether success or failure, enters the completion queue with its packet number and status word, and the transmit flag (status bit0) is set.
- R4: Reading address 3 returns the head packet number in bits 5:0 with bit7 at 0. Reading address 4 returns its status word, and a write to address 4 pops it. Several completions are kept in arrival order.
- R5: Reading address 3 while the completion queue is empty returns 0x0080.
- R6: With auto-release set, a successful completion is not queued and does not set the transmit flag. `rel_valid` pulses for one cycle, one cycle after `done_valid`, with `rel_pnum` equal to the packet number.
- R7: A fatal completion in either mode is queued, sets the transmit flag and sets halted (control bit4). While halted, `tx_head_valid` stays low even if packets are waiting. Writing control bit3 as 1 resumes the engine.
- R8: The empty flag (status bit1) is set only by a successful completion that leaves the transmit queue empty with no other packet in flight.
- R9: `irq` is high one cycle after (transmit flag AND bit1 of control) OR (empty flag AND bit2 of control) becomes true, and it falls the same way.
- R10: Writing 1 to status bit0 or bit1 clears that flag. Popping the last completion-queue entry also clears the transmit flag.
- R11: A submit while the transmit queue holds 8 entries is dropped and sets a sticky overflow flag (status bit5). Writing 1 to status bit5 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| tx_head_valid | output | 1 | A packet is available to the engine |
| tx_head_pnum | output | 6 | Packet number at the head of the transmit queue |
| tx_pop | input | 1 | Engine takes the head packet |
| done_valid | input | 1 | Engine reports a completion |
| done_ok | input | 1 | 1 means success, 0 means fatal error |
| done_pnum | input | 6 | Packet number of the completion |
| done_status | input | 16 | Status word of the completion |
| rel_valid | output | 1 | Memory release strobe |
| rel_pnum | output | 6 | Packet number to release |
| irq | output | 1 | Active-high interrupt |

## Verification
The main check is a sweep that sends all 64 packet numbers through both queues, in batches of eight, with auto-release off. Each status word is derived arithmetically from its packet number, so any mix-up of order or pairing between number and status shows up. Runs with auto-release on, all successful, separate the release path from the queued path. They also confirm that the empty flag stays low until the last packet of a batch completes. A fatal error in the middle of a batch with a packet still waiting shows apart halt from drain. Further patterns cover irq gating through the enables, clearing through both write-one and pop, and overflow on a ninth submission.

// File: rtl/txcq_pkg.sv
package txcq_pkg;
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_STATUS = 3'd1;
  localparam logic [2:0] ADDR_SUBMIT = 3'd2;
  localparam logic [2:0] ADDR_CQHEAD = 3'd3;
  localparam logic [2:0] ADDR_CQSTAT = 3'd4;

  localparam int CTRL_AUTOREL  = 0;
  localparam int CTRL_TXEN     = 1;
  localparam int CTRL_EMPTYEN  = 2;
  localparam int CTRL_RESUME   = 3;
  localparam int CTRL_HALTED   = 4;
  localparam int STAT_TXFLAG   = 0;
  localparam int STAT_EMPTYFLG = 1;
  localparam int STAT_OVF      = 5;
  localparam int HEAD_EMPTYBIT = 7;
endpackage

// File: rtl/txcq_fifo.sv
module txcq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic [AW:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txcq_flags.sv
module txcq_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_tx,
  input  logic set_empty,
  input  logic clr_tx,
  input  logic clr_empty,
  input  logic en_tx,
  input  logic en_empty,
  output logic tx_int,
  output logic empty_int,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_int    <= 1'b0;
      empty_int <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (set_tx)         tx_int <= 1'b1;
      else if (clr_tx)    tx_int <= 1'b0;
      if (set_empty)      empty_int <= 1'b1;
      else if (clr_empty) empty_int <= 1'b0;
      irq <= (tx_int && en_tx) || (empty_int && en_empty);
    end
  end
endmodule

// File: rtl/txcq_ctrl.sv
module txcq_ctrl
  import txcq_pkg::*;
#(
  parameter int PNUM_W = 6,
  parameter int STAT_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              tx_head_valid,
  output logic [PNUM_W-1:0] tx_head_pnum,
  input  logic              tx_pop,
  input  logic              done_valid,
  input  logic              done_ok,
  input  logic [PNUM_W-1:0] done_pnum,
  input  logic [STAT_W-1:0] done_status,
  output logic              rel_valid,
  output logic [PNUM_W-1:0] rel_pnum,
  output logic              irq
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CQ_W  = PNUM_W + STAT_W;
  localparam int FLT_W = AW + 2;

  logic wr_ctrl, wr_status, wr_submit, wr_cqpop;
  logic autorel, tx_en, empty_en, halted_q, ovf;
  logic txq_empty, txq_full, cq_empty, cq_full;
  logic [AW:0] txq_count, cq_count;
  logic [CQ_W-1:0] cq_dout;
  logic [PNUM_W-1:0] cq_pnum;
  logic [STAT_W-1:0] cq_stat;
  logic sub_push, eng_pop, ok_release, cq_push, fatal, last_done, cq_pop_ok;
  logic tx_int, empty_int;
  logic [FLT_W-1:0] inflight;
  logic [STAT_W-1:0] head_word, rd_mux;

  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_status = reg_wr && (reg_addr == ADDR_STATUS);
  assign wr_submit = reg_wr && (reg_addr == ADDR_SUBMIT);
  assign wr_cqpop  = reg_wr && (reg_addr == ADDR_CQSTAT);

  assign sub_push      = wr_submit;
  assign tx_head_valid = !txq_empty && !halted_q;
  assign eng_pop       = tx_pop && tx_head_valid;

  txcq_fifo #(.W(PNUM_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(sub_push), .din(reg_wdata[PNUM_W-1:0]),
    .pop(eng_pop), .dout(tx_head_pnum), .empty(txq_empty), .full(txq_full),
    .count(txq_count)
  );

  assign ok_release = done_valid && done_ok && autorel;
  assign cq_push    = done_valid && !ok_release;
  assign fatal      = done_valid && !done_ok;
  assign last_done  = done_valid && done_ok && txq_empty && (inflight == FLT_W'(1));
  assign cq_pop_ok  = wr_cqpop && !cq_empty;

  txcq_fifo #(.W(CQ_W), .DEPTH(DEPTH)) u_cq (
    .clk(clk), .rst(rst), .push(cq_push), .din({done_pnum, done_status}),
    .pop(wr_cqpop), .dout(cq_dout), .empty(cq_empty), .full(cq_full),
    .count(cq_count)
  );
  assign {cq_pnum, cq_stat} = cq_dout;

  txcq_flags u_flags (
    .clk(clk), .rst(rst),
    .set_tx(cq_push),
    .set_empty(last_done),
    .clr_tx((wr_status && reg_wdata[STAT_TXFLAG]) ||
            (cq_pop_ok && (cq_count == (AW+1)'(1)))),
    .clr_empty(wr_status && reg_wdata[STAT_EMPTYFLG]),
    .en_tx(tx_en), .en_empty(empty_en),
    .tx_int(tx_int), .empty_int(empty_int), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      autorel  <= 1'b0;
      tx_en    <= 1'b0;
      empty_en <= 1'b0;
      halted_q <= 1'b0;
      ovf      <= 1'b0;
      inflight <= '0;
      rel_valid <= 1'b0;
      rel_pnum  <= '0;
    end else begin
      if (wr_ctrl) begin
        autorel  <= reg_wdata[CTRL_AUTOREL];
        tx_en    <= reg_wdata[CTRL_TXEN];
        empty_en <= reg_wdata[CTRL_EMPTYEN];
      end
      if (fatal)                                   halted_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[CTRL_RESUME])  halted_q <= 1'b0;
      if (sub_push && txq_full)                    ovf <= 1'b1;
      else if (wr_status && reg_wdata[STAT_OVF])   ovf <= 1'b0;
      case ({eng_pop, done_valid && (inflight != '0)})
        2'b10:   inflight <= inflight + 1'b1;
        2'b01:   inflight <= inflight - 1'b1;
        default: inflight <= inflight;
      endcase
      rel_valid <= ok_release;
      if (ok_release) rel_pnum <= done_pnum;
    end
  end

  always_comb begin
    head_word = '0;
    if (cq_empty) head_word[HEAD_EMPTYBIT] = 1'b1;
    else          head_word[PNUM_W-1:0]    = cq_pnum;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        rd_mux[CTRL_AUTOREL] = autorel;
        rd_mux[CTRL_TXEN]    = tx_en;
        rd_mux[CTRL_EMPTYEN] = empty_en;
        rd_mux[CTRL_HALTED]  = halted_q;
      end
      ADDR_STATUS: begin
        rd_mux[STAT_TXFLAG]   = tx_int;
        rd_mux[STAT_EMPTYFLG] = empty_int;
        rd_mux[STAT_OVF]      = ovf;
      end
      ADDR_CQHEAD: rd_mux = head_word;
      ADDR_CQSTAT: rd_mux = cq_empty ? '0 : cq_stat;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/txcq_chk.sv
module txcq_chk #(
  parameter int PNUM_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              done_valid,
  input logic              done_ok,
  input logic [PNUM_W-1:0] done_pnum,
  input logic              rel_valid,
  input logic [PNUM_W-1:0] rel_pnum,
  input logic              halted_q,
  input logic              tx_head_valid,
  input logic              sub_push,
  input logic              txq_full,
  input logic              ovf,
  input logic              irq,
  input logic              tx_en,
  input logic              empty_en,
  input logic              empty_int
);
  AST_RELEASE_FROM_OK: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> ($past(done_valid && done_ok) && rel_pnum == $past(done_pnum))); // R6
  AST_HALT_ON_FATAL: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_ok) |=> halted_q); // R7
  AST_HALT_BLOCKS_HEAD: assert property (@(posedge clk) disable iff (rst)
    halted_q |-> !tx_head_valid); // R7
  AST_EMPTY_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_int) |-> $past(done_valid && done_ok)); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tx_en || empty_en)); // R9
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (sub_push && txq_full) |=> ovf); // R11
endmodule

bind txcq_ctrl txcq_chk #(.PNUM_W(PNUM_W)) u_chk (
  .clk(clk), .rst(rst), .done_valid(done_valid), .done_ok(done_ok),
  .done_pnum(done_pnum), .rel_valid(rel_valid), .rel_pnum(rel_pnum),
  .halted_q(halted_q), .tx_head_valid(tx_head_valid), .sub_push(sub_push),
  .txq_full(txq_full), .ovf(ovf), .irq(irq), .tx_en(tx_en),
  .empty_en(empty_en), .empty_int(empty_int)
);

// File: tb/test_txcq_ctrl.sv
module test_txcq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic tx_head_valid;
  logic [5:0] tx_head_pnum;
  logic tx_pop = 0, done_valid = 0, done_ok = 0;
  logic [5:0] done_pnum = '0;
  logic [15:0] done_status = '0;
  logic rel_valid;
  logic [5:0] rel_pnum;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] rd;

  always #4 clk = ~clk;

  txcq_ctrl i_txcq_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_head_valid(tx_head_valid),
    .tx_head_pnum(tx_head_pnum), .tx_pop(tx_pop), .done_valid(done_valid),
    .done_ok(done_ok), .done_pnum(done_pnum), .done_status(done_status),
    .rel_valid(rel_valid), .rel_pnum(rel_pnum), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic take(input logic [5:0] p, input string req);
    @(negedge clk);
    chk(req, {tx_head_valid, 2'b0, tx_head_pnum}, {1'b1, 2'b0, p});
    tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic finish_pkt(input logic [5:0] p, input logic ok, input logic [15:0] s);
    @(negedge clk); done_valid = 1; done_ok = ok; done_pnum = p; done_status = s;
    @(negedge clk); done_valid = 0;
  endtask

  function automatic logic [15:0] stat_of(input int p);
    return 16'((p * 997) ^ 16'h5A00);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 head", tx_head_valid, 0);
    rdr(3'd1, rd); chk("R1 status", rd, 0);
    rdr(3'd3, rd); chk("R5 empty head", rd, 16'h0080);

    // Sweep all 64 packet numbers, auto-release off
    wr(3'd0, 16'h0006);
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 8; i++) wr(3'd2, 16'(b*8+i));
      for (int i = 0; i < 8; i++) take(6'(b*8+i), "R2 order");
      for (int i = 0; i < 8; i++) begin
        finish_pkt(6'(b*8+i), 1'b1, stat_of(b*8+i));
        if (i == 6) begin
          rdr(3'd1, rd); chk("R8 not early", rd[1], 0);
        end
      end
      rdr(3'd1, rd); chk("R3 tx flag", rd[1:0], 2'b11);
      chk("R9 irq set", irq, 1);
      for (int i = 0; i < 8; i++) begin
        rdr(3'd3, rd); chk("R4 head", rd, 16'(b*8+i));
        rdr(3'd4, rd); chk("R3 status word", rd, stat_of(b*8+i));
        wr(3'd4, 16'h0);
      end
      rdr(3'd1, rd); chk("R10 pop clears", rd[1:0], 2'b10);
      wr(3'd1, 16'h0002);
      rdr(3'd1, rd); chk("R10 w1c empty", rd[1:0], 2'b00);
      chk("R9 irq low", irq, 0);
      rdr(3'd3, rd); chk("R5 empty again", rd, 16'h0080);
    end

    // Auto-release, all successful
    wr(3'd0, 16'h0007);
    for (int i = 0; i < 4; i++) wr(3'd2, 16'(40+i));
    for (int i = 0; i < 4; i++) take(6'(40+i), "R2 order ar");
    for (int i = 0; i < 4; i++) begin
      finish_pkt(6'(40+i), 1'b1, 16'h1111);
      chk("R6 rel strobe", {rel_valid, 2'b0, rel_pnum}, {1'b1, 2'b0, 6'(40+i)});
      @(negedge clk);
      chk("R6 rel one cycle", rel_valid, 0);
      rdr(3'd1, rd);
      chk("R8 empty only at last", rd[1:0], (i == 3) ? 2'b10 : 2'b00);
    end
    rdr(3'd3, rd); chk("R6 not queued", rd, 16'h0080);
    wr(3'd1, 16'h0003);

    // Fatal error mid-batch with auto-release
    for (int i = 0; i < 3; i++) wr(3'd2, 16'(50+i));
    take(6'd50, "R2 f0");
    finish_pkt(6'd50, 1'b1, 16'h0);
    take(6'd51, "R2 f1");
    finish_pkt(6'd51, 1'b0, 16'hDEAD);
    chk("R7 no release", rel_valid, 0);
    rdr(3'd1, rd); chk("R7 tx flag", rd[1:0], 2'b01);
    rdr(3'd3, rd); chk("R7 queued", rd, 16'd51);
    rdr(3'd4, rd); chk("R7 status", rd, 16'hDEAD);
    chk("R7 head blocked", tx_head_valid, 0);
    rdr(3'd0, rd); chk("R7 halted", rd, 16'h0017);
    wr(3'd0, 16'h000F);
    rdr(3'd0, rd); chk("R7 resumed", rd, 16'h0007);
    take(6'd52, "R7 resume head");
    finish_pkt(6'd52, 1'b1, 16'h0);
    rdr(3'd1, rd); chk("R8 after resume", rd[1:0], 2'b11);
    wr(3'd4, 16'h0);
    rdr(3'd1, rd); chk("R10 pop last", rd[1:0], 2'b10);
    wr(3'd1, 16'h0002);

    // Interrupt enable gating, auto-release off
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd60);
    take(6'd60, "R2 g");
    finish_pkt(6'd60, 1'b1, 16'h0);
    wr(3'd1, 16'h0002);
    rdr(3'd1, rd); chk("R3 flag gated", rd[1:0], 2'b01);
    chk("R9 masked", irq, 0);
    wr(3'd0, 16'h0002);
    @(negedge clk);
    chk("R9 enabled", irq, 1);
    wr(3'd1, 16'h0001);
    @(negedge clk);
    chk("R10 w1c tx", irq, 0);
    rdr(3'd3, rd); chk("R10 entry kept", rd, 16'd60);
    wr(3'd4, 16'h0);

    // Overflow
    for (int i = 0; i < 9; i++) wr(3'd2, 16'(i+10));
    rdr(3'd1, rd); chk("R11 ovf set", rd[5], 1);
    for (int i = 0; i < 8; i++) take(6'(i+10), "R11 kept");
    @(negedge clk);
    chk("R11 ninth dropped", tx_head_valid, 0);
    wr(3'd1, 16'h0020);
    rdr(3'd1, rd); chk("R11 ovf cleared", rd[5], 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule